// File: doc/BRIEF.md
# NAND Write-Posting Engine

The block takes bytes that a host or DMA channel pushes into an internal byte FIFO and replays them as single-byte write requests to one NAND chip-select. It uses a simple request/acknowledge handshake for each byte. Software sets up the engine through a small register set:

- an enable bit;
- a direction (access-mode) bit;
- a synchronisation-mode bit;
- a chip-select index from 0 to 3;
- a DMA threshold;
- a 14-bit byte count.

Software then writes the start bit. The start bit stays set while the engine works and clears itself once the counted number of bytes has been acknowledged.

A NAND command sequencer outside the block reports through `cmd_busy` that a command or address phase is still in progress. A start that arrives during such a phase is held pending until the phase ends, so the posted data never overlaps the address cycles. The DMA request is paced by the threshold. It is raised only when the FIFO has room for a whole burst of threshold bytes and the page still needs data. It drops as soon as that burst has been written.

Register map (word addresses):

| Address | Name | Access | Fields |
|---|---|---|---|
| 0 | configuration | read/write | bit 0 enable, bit 1 direction (1 = post writes), bit 2 sync mode, bits 5:4 chip-select, bits 14:8 threshold |
| 1 | byte count | read/write | bits 13:0 byte count |
| 2 | control | read/write | bit 0 start |
| 3 | status | read-only, except overflow clear | bits 13:0 remaining bytes, bits 22:16 FIFO fill, bit 24 sticky overflow |

Read data is registered: `reg_rdata` shows the register selected by `reg_addr` one clock later.

Top module: `nand_wpost_engine`

## Requirements
- R1: After reset the start bit, `mem_wr_req`, `dma_req`, the remaining count, the FIFO fill and the overflow flag are all 0.
- R2: A write of 1 to control bit 0 starts the engine only when the configuration has enable = 1, direction = 1 and sync mode = 0. Otherwise the start bit stays 0.
- R3: If `cmd_busy` is high when the engine starts, no write request is raised until `cmd_busy` has gone low.
- R4: Each write request carries the configured chip-select index and the FIFO bytes in the order they were pushed. `mem_wr_req`, `mem_wr_data` and `mem_wr_cs` stay stable until `mem_wr_ack` is seen.
- R5: No write request is raised while the FIFO is empty; the engine waits with the start bit set.
- R6: Exactly the programmed number of bytes is written. The remaining count (status bits 13:0) counts down, and the start bit returns to 0 on the acknowledge of the last byte.
- R7: A start with a byte count of 0 leaves the start bit at 0 and issues no write request.
- R8: Writes to the configuration and byte-count registers while the start bit is 1 are ignored.
- R9: `dma_req` is raised while running when free FIFO space is at least the threshold (a threshold of 0 counts as 1, above 64 as 64) and the remaining count exceeds the bytes already buffered. It drops right after the threshold-th accepted FIFO write, and it is 0 whenever the start bit is 0.
- R10: A FIFO write while 64 bytes are stored is discarded and sets status bit 24. Bit 24 stays set until a status write with bit 24 = 1.
- R11: Status bits 22:16 report the number of bytes held in the FIFO (0 to 64).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| fifo_wr | input | 1 | FIFO byte write strobe |
| fifo_wdata | input | 8 | FIFO write byte |
| dma_req | output | 1 | DMA request for a burst of threshold bytes |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_cs | output | 2 | Chip-select index of the request |
| mem_wr_data | output | 8 | Byte to write |
| mem_wr_ack | input | 1 | Acknowledge that completes the request |
| cmd_busy | input | 1 | NAND command/address phase still in progress |

## Verification
The bench goes after the start paths that must do nothing: a zero count, a wrong mode and sync mode set. A design that got these wrong would raise the start bit or emit a stray write. A start issued while `cmd_busy` is high and with an empty FIFO must produce no request. An engine that ignored either condition would post garbage or post ahead of the address phase.

It holds back the acknowledge to catch a request whose data or chip-select slips before acceptance. It rewrites the configuration mid-transfer to catch a missing lock, which would redirect bytes to another chip-select. It overfills the FIFO to catch a dropped byte in the wrong place or an overflow flag that is not sticky. It watches `dma_req` fall right after each threshold burst, where a wrong pacing rule would leave it high or never raise it.

// File: rtl/wpost_pkg.sv
package wpost_pkg;
  localparam int CS_W  = 2;
  localparam int THR_W = 7;

  localparam logic [1:0] ADDR_CFG    = 2'd0;
  localparam logic [1:0] ADDR_COUNT  = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;

  localparam int BIT_EN    = 0;
  localparam int BIT_MODE  = 1;
  localparam int BIT_SYNC  = 2;
  localparam int LSB_CS    = 4;
  localparam int LSB_THR   = 8;
  localparam int LSB_FILL  = 16;
  localparam int BIT_OVF   = 24;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_WAIT,
    ST_LOAD,
    ST_REQ
  } post_state_t;
endpackage

// File: rtl/wpost_fifo.sv
module wpost_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [DW-1:0]                     wr_data,
  input  logic                              rd_en,
  output logic [DW-1:0]                     rd_data,
  output logic [$clog2(DEPTH+1)-1:0]        count,
  output logic                              empty,
  output logic                              wr_ok,
  output logic                              ovf_hit
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH-1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, rd_ok;

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign wr_ok   = wr_en && !full;
  assign ovf_hit = wr_en && full;
  assign rd_ok   = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
    if (rd_ok) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (rd_ok) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/wpost_regs.sv
module wpost_regs
  import wpost_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int FILL_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               running,
  input  logic [CNT_W-1:0]   rem,
  input  logic [FILL_W-1:0]  fill,
  input  logic               ovf_hit,
  output logic               cfg_en,
  output logic               cfg_mode,
  output logic               cfg_sync,
  output logic [CS_W-1:0]    cfg_cs,
  output logic [THR_W-1:0]   cfg_thr,
  output logic [CNT_W-1:0]   cfg_count,
  output logic               start_wr
);
  logic        ovf_q;
  logic [31:0] rd_next;

  assign start_wr = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_en    <= 1'b0;
      cfg_mode  <= 1'b0;
      cfg_sync  <= 1'b0;
      cfg_cs    <= '0;
      cfg_thr   <= '0;
      cfg_count <= '0;
    end else if (reg_wr && !running) begin
      if (reg_addr == ADDR_CFG) begin
        cfg_en   <= reg_wdata[BIT_EN];
        cfg_mode <= reg_wdata[BIT_MODE];
        cfg_sync <= reg_wdata[BIT_SYNC];
        cfg_cs   <= reg_wdata[LSB_CS +: CS_W];
        cfg_thr  <= reg_wdata[LSB_THR +: THR_W];
      end
      if (reg_addr == ADDR_COUNT) cfg_count <= reg_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ovf_q <= 1'b0;
    else if (ovf_hit) ovf_q <= 1'b1;
    else if (reg_wr && reg_addr == ADDR_STATUS && reg_wdata[BIT_OVF]) ovf_q <= 1'b0;
  end

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      ADDR_CFG: begin
        rd_next[BIT_EN]             = cfg_en;
        rd_next[BIT_MODE]           = cfg_mode;
        rd_next[BIT_SYNC]           = cfg_sync;
        rd_next[LSB_CS +: CS_W]     = cfg_cs;
        rd_next[LSB_THR +: THR_W]   = cfg_thr;
      end
      ADDR_COUNT: rd_next[CNT_W-1:0] = cfg_count;
      ADDR_CTRL:  rd_next[0]         = running;
      default: begin
        rd_next[CNT_W-1:0]          = rem;
        rd_next[LSB_FILL +: FILL_W] = fill;
        rd_next[BIT_OVF]            = ovf_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/wpost_ctrl.sv
module wpost_ctrl
  import wpost_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_wr,
  input  logic              cfg_en,
  input  logic              cfg_mode,
  input  logic              cfg_sync,
  input  logic [CS_W-1:0]   cfg_cs,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              fifo_empty,
  input  logic [DW-1:0]     fifo_rd_data,
  output logic              fifo_rd_en,
  input  logic              cmd_busy,
  input  logic              mem_wr_ack,
  output logic              mem_wr_req,
  output logic [CS_W-1:0]   mem_wr_cs,
  output logic [DW-1:0]     mem_wr_data,
  output logic              start_q,
  output logic              pending,
  output logic              inflight,
  output logic [CNT_W-1:0]  rem
);
  post_state_t st;
  logic        go_ok;

  assign go_ok      = start_wr && cfg_en && cfg_mode && !cfg_sync && (cfg_count != '0);
  assign fifo_rd_en = (st == ST_WAIT) && !fifo_empty;
  assign pending    = (st == ST_PEND);
  assign inflight   = (st == ST_LOAD) || (st == ST_REQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      start_q     <= 1'b0;
      rem         <= '0;
      mem_wr_req  <= 1'b0;
      mem_wr_cs   <= '0;
      mem_wr_data <= '0;
    end else begin
      case (st)
        ST_IDLE: if (go_ok) begin
          start_q   <= 1'b1;
          rem       <= cfg_count;
          mem_wr_cs <= cfg_cs;
          st        <= ST_PEND;
        end
        ST_PEND: if (!cmd_busy) st <= ST_WAIT;
        ST_WAIT: if (!fifo_empty) st <= ST_LOAD;
        ST_LOAD: begin
          mem_wr_req  <= 1'b1;
          mem_wr_data <= fifo_rd_data;
          st          <= ST_REQ;
        end
        ST_REQ: if (mem_wr_ack) begin
          mem_wr_req <= 1'b0;
          rem        <= rem - 1'b1;
          if (rem == CNT_W'(1)) begin
            start_q <= 1'b0;
            st      <= ST_IDLE;
          end else begin
            st <= ST_WAIT;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wpost_dma.sv
module wpost_dma
  import wpost_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 14
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_q,
  input  logic [THR_W-1:0]            cfg_thr,
  input  logic [$clog2(DEPTH+1)-1:0]  fifo_count,
  input  logic                        fifo_wr_ok,
  input  logic [CNT_W-1:0]            rem,
  input  logic                        inflight,
  output logic                        dma_req
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int TW = (CW > THR_W) ? CW : THR_W;

  logic [CW-1:0] thr_eff, free, burst;
  logic [CNT_W:0] held;
  logic           need;

  always_comb begin
    if (cfg_thr == '0)                     thr_eff = CW'(1);
    else if (TW'(cfg_thr) > TW'(DEPTH))    thr_eff = CW'(DEPTH);
    else                                   thr_eff = CW'(cfg_thr);
  end

  assign free = CW'(DEPTH) - fifo_count;
  assign held = (CNT_W+1)'(fifo_count) + (CNT_W+1)'(inflight);
  assign need = (CNT_W+1)'(rem) > held;

  always_ff @(posedge clk) begin
    if (rst || !start_q) begin
      dma_req <= 1'b0;
      burst   <= '0;
    end else if (dma_req) begin
      if (fifo_wr_ok) begin
        if (burst + 1'b1 == thr_eff) begin
          dma_req <= 1'b0;
          burst   <= '0;
        end else begin
          burst <= burst + 1'b1;
        end
      end
    end else if (free >= thr_eff && need) begin
      dma_req <= 1'b1;
      burst   <= '0;
    end
  end
endmodule

// File: rtl/nand_wpost_engine.sv
module nand_wpost_engine
  import wpost_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             fifo_wr,
  input  logic [DW-1:0]    fifo_wdata,
  output logic             dma_req,
  output logic             mem_wr_req,
  output logic [CS_W-1:0]  mem_wr_cs,
  output logic [DW-1:0]    mem_wr_data,
  input  logic             mem_wr_ack,
  input  logic             cmd_busy
);
  localparam int CW = $clog2(DEPTH+1);

  logic              cfg_en, cfg_mode, cfg_sync, start_wr;
  logic [CS_W-1:0]   cfg_cs;
  logic [THR_W-1:0]  cfg_thr;
  logic [CNT_W-1:0]  cfg_count, rem;
  logic              start_q, pending, inflight;
  logic              fifo_rd_en, fifo_empty, fifo_wr_ok, ovf_hit;
  logic [DW-1:0]     fifo_rd_data;
  logic [CW-1:0]     fifo_count;

  wpost_regs #(.CNT_W(CNT_W), .FILL_W(CW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .running(start_q),
    .rem(rem), .fill(fifo_count), .ovf_hit(ovf_hit),
    .cfg_en(cfg_en), .cfg_mode(cfg_mode), .cfg_sync(cfg_sync),
    .cfg_cs(cfg_cs), .cfg_thr(cfg_thr), .cfg_count(cfg_count),
    .start_wr(start_wr)
  );

  wpost_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(fifo_wr), .wr_data(fifo_wdata),
    .rd_en(fifo_rd_en), .rd_data(fifo_rd_data), .count(fifo_count),
    .empty(fifo_empty), .wr_ok(fifo_wr_ok), .ovf_hit(ovf_hit)
  );

  wpost_ctrl #(.DW(DW), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start_wr(start_wr), .cfg_en(cfg_en),
    .cfg_mode(cfg_mode), .cfg_sync(cfg_sync), .cfg_cs(cfg_cs),
    .cfg_count(cfg_count), .fifo_empty(fifo_empty),
    .fifo_rd_data(fifo_rd_data), .fifo_rd_en(fifo_rd_en),
    .cmd_busy(cmd_busy), .mem_wr_ack(mem_wr_ack), .mem_wr_req(mem_wr_req),
    .mem_wr_cs(mem_wr_cs), .mem_wr_data(mem_wr_data), .start_q(start_q),
    .pending(pending), .inflight(inflight), .rem(rem)
  );

  wpost_dma #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dma (
    .clk(clk), .rst(rst), .start_q(start_q), .cfg_thr(cfg_thr),
    .fifo_count(fifo_count), .fifo_wr_ok(fifo_wr_ok), .rem(rem),
    .inflight(inflight), .dma_req(dma_req)
  );
endmodule

// File: rtl/wpost_chk.sv
module wpost_chk
  import wpost_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int CNT_W = 14
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        start_q,
  input logic                        pending,
  input logic                        cmd_busy,
  input logic                        mem_wr_req,
  input logic                        mem_wr_ack,
  input logic [DW-1:0]               mem_wr_data,
  input logic [CS_W-1:0]             mem_wr_cs,
  input logic                        dma_req,
  input logic [CNT_W+THR_W+CS_W+2:0] cfg_all,
  input logic [$clog2(DEPTH+1)-1:0]  fifo_count,
  input logic [CNT_W-1:0]            rem
);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_data) && $stable(mem_wr_cs)));

  assert_busy_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    (pending && cmd_busy) |=> !mem_wr_req);

  assert_idle_no_req_R6: assert property (@(posedge clk) disable iff (rst)
    !start_q |-> !mem_wr_req);

  assert_run_rem_R6: assert property (@(posedge clk) disable iff (rst)
    start_q |-> (rem != '0));

  assert_cfg_lock_R8: assert property (@(posedge clk) disable iff (rst)
    start_q |=> $stable(cfg_all));

  assert_dma_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !start_q |=> !dma_req);

  assert_fill_bound_R11: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind nand_wpost_engine wpost_chk #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start_q(start_q), .pending(pending),
  .cmd_busy(cmd_busy), .mem_wr_req(mem_wr_req), .mem_wr_ack(mem_wr_ack),
  .mem_wr_data(mem_wr_data), .mem_wr_cs(mem_wr_cs), .dma_req(dma_req),
  .cfg_all({cfg_en, cfg_mode, cfg_sync, cfg_cs, cfg_thr, cfg_count}),
  .fifo_count(fifo_count), .rem(rem)
);

// File: tb/nand_wpost_engine_tb.sv
module nand_wpost_engine_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        fifo_wr = 0;
  logic [7:0]  fifo_wdata = 0;
  logic        dma_req, mem_wr_req;
  logic [1:0]  mem_wr_cs;
  logic [7:0]  mem_wr_data;
  logic        mem_wr_ack = 0;
  logic        cmd_busy = 0;

  int checks = 0, failures = 0;
  bit ack_auto = 1;
  bit finished = 0;
  int log_n = 0;
  logic [7:0] log_data [256];
  logic [1:0] log_cs [256];

  always #2 clk = ~clk;

  nand_wpost_engine u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_wr(fifo_wr),
    .fifo_wdata(fifo_wdata), .dma_req(dma_req), .mem_wr_req(mem_wr_req),
    .mem_wr_cs(mem_wr_cs), .mem_wr_data(mem_wr_data),
    .mem_wr_ack(mem_wr_ack), .cmd_busy(cmd_busy)
  );

  always @(negedge clk) begin
    if (mem_wr_ack) mem_wr_ack = 0;
    else if (mem_wr_req && ack_auto) begin
      log_data[log_n] = mem_wr_data;
      log_cs[log_n]   = mem_wr_cs;
      log_n = log_n + 1;
      mem_wr_ack = 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cfgv(bit en, bit mode, bit sync, logic [1:0] cs, logic [6:0] thr);
    return {17'b0, thr, 2'b0, cs, 1'b0, sync, mode, en};
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    fifo_wr = 1; fifo_wdata = b;
    @(negedge clk);
    fifo_wr = 0;
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] d;
    int n;
    n = 0;
    d = 1;
    while (d[0] && n < 2000) begin
      reg_read(2'd2, d);
      n++;
    end
    check(d[0] == 0, tag, d[0], 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(mem_wr_req == 0 && dma_req == 0, "R1 outputs", {mem_wr_req, dma_req}, 0);
    reg_read(2'd3, d);
    check(d == 0, "R1 status", d, 0);
    reg_read(2'd2, d);
    check(d == 0, "R1 start", d, 0);
  endtask

  task automatic t_guard();
    logic [31:0] d;
    reg_write(2'd1, 32'd2);
    reg_write(2'd0, cfgv(1, 0, 0, 0, 4));
    reg_write(2'd2, 1);
    reg_read(2'd2, d);
    check(d[0] == 0, "R2 mode=0", d[0], 0);
    reg_write(2'd0, cfgv(1, 1, 1, 0, 4));
    reg_write(2'd2, 1);
    reg_read(2'd2, d);
    check(d[0] == 0, "R2 sync=1", d[0], 0);
    reg_write(2'd0, cfgv(0, 1, 0, 0, 4));
    reg_write(2'd2, 1);
    reg_read(2'd2, d);
    check(d[0] == 0, "R2 enable=0", d[0], 0);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    log_n = 0;
    push(8'h11);
    reg_write(2'd0, cfgv(1, 1, 0, 1, 4));
    reg_write(2'd1, 0);
    reg_write(2'd2, 1);
    reg_read(2'd2, d);
    check(d[0] == 0, "R7 start bit", d[0], 0);
    repeat (10) @(negedge clk);
    check(log_n == 0, "R7 no write", log_n, 0);
    reg_write(2'd1, 1);
    reg_write(2'd2, 1);
    wait_done("R7 drain");
  endtask

  task automatic t_basic();
    logic [31:0] d;
    bit ok;
    log_n = 0;
    reg_write(2'd0, cfgv(1, 1, 0, 2, 4));
    reg_write(2'd1, 5);
    for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i));
    reg_write(2'd2, 1);
    wait_done("R6 self clear");
    ok = (log_n == 5);
    for (int i = 0; i < 5; i++)
      if (log_data[i] != 8'hA0 + 8'(i) || log_cs[i] != 2) ok = 0;
    check(ok, "R4 order and cs", log_n, 5);
    reg_read(2'd3, d);
    check(d[13:0] == 0 && d[22:16] == 0, "R6 remaining zero", d, 0);
  endtask

  task automatic t_empty();
    logic [31:0] d;
    log_n = 0;
    reg_write(2'd0, cfgv(1, 1, 0, 3, 4));
    reg_write(2'd1, 3);
    reg_write(2'd2, 1);
    repeat (20) @(negedge clk);
    check(log_n == 0 && mem_wr_req == 0, "R5 no req empty", log_n, 0);
    reg_read(2'd3, d);
    check(d[13:0] == 3, "R6 remaining", d[13:0], 3);
    push(8'h01);
    repeat (10) @(negedge clk);
    reg_read(2'd3, d);
    check(d[13:0] == 2 && log_n == 1, "R6 countdown", d[13:0], 2);
    push(8'h02); push(8'h03);
    wait_done("R5 done");
    check(log_n == 3 && log_data[2] == 8'h03, "R5 data", log_n, 3);
  endtask

  task automatic t_busy();
    log_n = 0;
    cmd_busy = 1;
    reg_write(2'd0, cfgv(1, 1, 0, 1, 4));
    reg_write(2'd1, 2);
    push(8'h55); push(8'h66);
    reg_write(2'd2, 1);
    repeat (20) @(negedge clk);
    check(log_n == 0 && mem_wr_req == 0, "R3 held by busy", log_n, 0);
    cmd_busy = 0;
    wait_done("R3 done");
    check(log_n == 2 && log_data[0] == 8'h55, "R3 data", log_n, 2);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    log_n = 0;
    reg_write(2'd0, cfgv(1, 1, 0, 2, 4));
    reg_write(2'd1, 4);
    reg_write(2'd2, 1);
    reg_write(2'd0, cfgv(1, 1, 0, 1, 9));
    reg_write(2'd1, 9);
    reg_read(2'd0, d);
    check(d == cfgv(1, 1, 0, 2, 4), "R8 cfg locked", d, cfgv(1, 1, 0, 2, 4));
    reg_read(2'd1, d);
    check(d == 4, "R8 count locked", d, 4);
    for (int i = 0; i < 4; i++) push(8'(i));
    wait_done("R8 done");
    check(log_n == 4 && log_cs[3] == 2, "R8 cs kept", log_cs[3], 2);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    ack_auto = 0;
    log_n = 0;
    reg_write(2'd0, cfgv(1, 1, 0, 3, 4));
    reg_write(2'd1, 1);
    push(8'h5A);
    reg_write(2'd2, 1);
    repeat (10) @(negedge clk);
    check(mem_wr_req && mem_wr_data == 8'h5A && mem_wr_cs == 3, "R4 req", mem_wr_data, 8'h5A);
    v = mem_wr_data;
    repeat (15) @(negedge clk);
    check(mem_wr_req && mem_wr_data == v, "R4 held", mem_wr_data, v);
    ack_auto = 1;
    wait_done("R4 done");
    check(log_n == 1, "R4 single", log_n, 1);
  endtask

  task automatic t_fifo();
    logic [31:0] d;
    bit ok;
    log_n = 0;
    for (int i = 0; i < 3; i++) push(8'(i * 3 + 1));
    reg_read(2'd3, d);
    check(d[22:16] == 3, "R11 fill 3", d[22:16], 3);
    for (int i = 3; i < 64; i++) push(8'(i * 3 + 1));
    push(8'hEE); push(8'hEE);
    reg_read(2'd3, d);
    check(d[22:16] == 64 && d[24], "R10 full+ovf", d, 32'h0140_0000);
    repeat (5) @(negedge clk);
    reg_read(2'd3, d);
    check(d[24], "R10 sticky", d[24], 1);
    reg_write(2'd3, 32'h0100_0000);
    reg_read(2'd3, d);
    check(!d[24], "R10 cleared", d[24], 0);
    reg_write(2'd0, cfgv(1, 1, 0, 0, 4));
    reg_write(2'd1, 64);
    reg_write(2'd2, 1);
    wait_done("R10 drain");
    ok = (log_n == 64);
    for (int i = 0; i < 64; i++) if (log_data[i] != 8'(i * 3 + 1)) ok = 0;
    check(ok, "R10 data kept", log_n, 64);
  endtask

  task automatic t_dma();
    log_n = 0;
    reg_write(2'd0, cfgv(1, 1, 0, 1, 8));
    reg_write(2'd1, 20);
    check(dma_req == 0, "R9 idle", dma_req, 0);
    reg_write(2'd2, 1);
    repeat (3) @(negedge clk);
    check(dma_req == 1, "R9 raised", dma_req, 1);
    for (int i = 0; i < 8; i++) push(8'(i));
    check(dma_req == 0, "R9 drop after burst", dma_req, 0);
    while (!dma_req) @(negedge clk);
    for (int i = 8; i < 16; i++) push(8'(i));
    check(dma_req == 0, "R9 drop 2", dma_req, 0);
    while (!dma_req) @(negedge clk);
    for (int i = 16; i < 20; i++) push(8'(i));
    wait_done("R9 done");
    @(negedge clk);
    check(dma_req == 0 && log_n == 20 && log_data[19] == 19, "R9 end", log_n, 20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_guard();
    t_zero();
    t_basic();
    t_empty();
    t_busy();
    t_lock();
    t_hold();
    t_fifo();
    t_dma();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule